// File: doc/BRIEF.md
# Cache Way-Lock Victim Selector

This block holds the control state of a 4-way set-associative cache and decides, on every miss, which way receives the new line. A control register holds the cache enable bit, a one-shot flush bit and two write-policy bits, one per group of address regions. A second register can only be written. It holds a lock bit and a load bit for each of the two upper ways (way 2 and way 3).

The lock and load bits take effect only while an external lock-mode flag is high. In that state a prefetch miss is steered into an upper way whose load bit is set. An ordinary miss never evicts an upper way whose lock bit is set.

Each cycle the surrounding cache presents the per-way hit and valid vectors, a per-way age vector, a prefetch flag, the lock-mode flag and a region flag. One clock later the block returns a fill request, the way to fill, the write policy of the region and, after a flush write, a one-cycle clear strobe. The tag arrays, the data arrays and the bus side belong to other blocks.

Top module: `cache_victim_ctl`

## Requirements
- R1: After reset, `fill_req`, `fill_way`, `wr_back` and `flush_pulse` are 0, and the control register reads 0.
- R2: Control register bit 0 is the enable bit. A cycle with `acc_valid`=1, enable=1 and `hit`=0 raises `fill_req` on the following cycle. When enable=0, `fill_req` stays 0.
- R3: Writing control register bit 1 as 1 raises `flush_pulse` for exactly one cycle, in the cycle after the write. This strobe clears the valid, dirty and LRU state of every entry, and the flush requests no write-back of dirty lines. Bit 1 always reads back as 0.
- R4: When `rgn_direct`=1, `wr_back` on the next cycle equals control register bit 2. The value 1 means write-back and 0 means write-through.
- R5: When `rgn_direct`=0, `wr_back` on the next cycle is the inverse of control register bit 3. The value 1 in bit 3 means write-through.
- R6: When `lock_mode`=0, the lock register has no effect, and every miss picks its victim by the plain rule of R9 across all four ways.
- R7: The lock register is laid out as bit 0 lock way 2, bit 1 load way 2, bit 2 lock way 3, bit 3 load way 3. On a prefetch miss with `lock_mode`=1, the fill goes to way 3 if load way 3 is set. Otherwise it goes to way 2 if load way 2 is set. Otherwise the R9 rule picks the way.
- R8: When any bit of `hit` is set, `fill_req` is 0 on the next cycle, whether the access is a prefetch or not.
- R9: The victim is chosen among the allowed ways. An upper way is excluded when `lock_mode`=1 and its lock bit is set. The lowest-numbered invalid allowed way is taken first. If none is invalid, the allowed way with the largest age is taken, where age 3 means least recently used.
- R10: The lock register is write-only, and a read of it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_sel | input | 1 | 0 selects the control register, 1 selects the lock register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after `cfg_re` |
| acc_valid | input | 1 | An access is looked up this cycle |
| acc_pref | input | 1 | The access is a prefetch |
| lock_mode | input | 1 | External lock-mode flag |
| rgn_direct | input | 1 | The access falls in the region governed by bit 2 |
| hit | input | 4 | Per-way tag hit |
| valid | input | 4 | Per-way valid bits of the indexed set |
| age | input | 8 | Two-bit age per way, way i at bits 2i+1:2i, 3 = oldest |
| fill_req | output | 1 | Line fill request |
| fill_way | output | 2 | Way that receives the fill |
| wr_back | output | 1 | 1 = write-back policy, 0 = write-through |
| flush_pulse | output | 1 | One-cycle strobe that clears all entries |

## Verification
The selection logic is driven from a table of lookups that vary the lock-register contents, the lock-mode flag, the prefetch flag, the valid pattern and the age order. Some entries repeat the same lookup with lock mode on and then off, which separates "lock ignored" from "lock honoured". Other entries set both load bits, which exposes the priority between way 3 and way 2. Age orders in which a locked way is the oldest show whether the exclusion rule or the age rule wins, and an invalid locked way shows that exclusion overrides the preference for invalid ways. Directed steps cover hits in a non-designated way, the disabled cache, all four policy-bit combinations, flush strobe width and read-back, and the write-only register.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  localparam int NWAYS  = 4;
  localparam int WAY_W  = $clog2(NWAYS);
  localparam int AGE_W  = WAY_W;
  localparam int DATA_W = 32;

  // control register field positions
  localparam int CB_EN   = 0;
  localparam int CB_FLS  = 1;
  localparam int CB_PDIR = 2;
  localparam int CB_POTH = 3;

  // lock register field positions
  localparam int LB_LOCK_LO = 0;
  localparam int LB_LOAD_LO = 1;
  localparam int LB_LOCK_HI = 2;
  localparam int LB_LOAD_HI = 3;

  typedef struct packed {
    logic lock_lo;
    logic load_lo;
    logic lock_hi;
    logic load_hi;
  } lock_cfg_t;

  typedef struct packed {
    logic en;
    logic pol_direct;
    logic pol_other;
  } ctl_cfg_t;
endpackage

// File: rtl/cvs_cfg_regs.sv
module cvs_cfg_regs
  import cvs_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output ctl_cfg_t      ctl,
  output lock_cfg_t     lck,
  output logic          flush_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl         <= '0;
      lck         <= '0;
      flush_pulse <= 1'b0;
    end else begin
      flush_pulse <= we && !sel && wdata[CB_FLS];
      if (we && !sel) begin
        ctl.en         <= wdata[CB_EN];
        ctl.pol_direct <= wdata[CB_PDIR];
        ctl.pol_other  <= wdata[CB_POTH];
      end
      if (we && sel) begin
        lck.lock_lo <= wdata[LB_LOCK_LO];
        lck.load_lo <= wdata[LB_LOAD_LO];
        lck.lock_hi <= wdata[LB_LOCK_HI];
        lck.load_hi <= wdata[LB_LOAD_HI];
      end
    end
  end

  // read port: flush bit and whole lock register read as zero
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= '0;
      if (!sel) begin
        rdata[CB_EN]   <= ctl.en;
        rdata[CB_PDIR] <= ctl.pol_direct;
        rdata[CB_POTH] <= ctl.pol_other;
      end
    end
  end

  // R10: the lock register reads back as zero
  a_r10_lock_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (re && sel) |=> (rdata == '0));
  // R3: the strobe never lasts two cycles
  a_r3_flush_one_cycle: assert property (@(posedge clk) disable iff (rst)
    flush_pulse |=> !flush_pulse);
endmodule

// File: rtl/cvs_victim_pick.sv
module cvs_victim_pick
  import cvs_pkg::*;
#(
  parameter int NW = NWAYS,
  parameter int AW = AGE_W,
  localparam int WW = $clog2(NW)
) (
  input  logic [NW-1:0]    valid,
  input  logic [NW*AW-1:0] age,
  input  logic [NW-1:0]    excl,
  output logic [WW-1:0]    victim
);
  logic [NW-1:0]   allow;
  logic [AW-1:0]   age_w [NW];

  for (genvar g = 0; g < NW; g++) begin : g_way
    assign allow[g] = !excl[g];
    assign age_w[g] = age[g*AW +: AW];
  end

  logic          inv_found;
  logic [WW-1:0] inv_way;
  logic [WW-1:0] old_way;
  logic [AW-1:0] best_age;
  logic          have;

  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      if (allow[i] && !valid[i]) begin
        inv_found = 1'b1;
        inv_way   = WW'(i);
      end
    end
    have     = 1'b0;
    best_age = '0;
    old_way  = '0;
    for (int i = 0; i < NW; i++) begin
      if (allow[i] && (!have || age_w[i] > best_age)) begin
        have     = 1'b1;
        best_age = age_w[i];
        old_way  = WW'(i);
      end
    end
    victim = inv_found ? inv_way : old_way;
  end
endmodule

// File: rtl/cache_victim_ctl.sv
module cache_victim_ctl
  import cvs_pkg::*;
#(
  parameter int NW       = NWAYS,
  parameter int DW       = DATA_W,
  parameter int WAY_LO   = 2,
  parameter int WAY_HI   = 3,
  localparam int WW      = $clog2(NW),
  localparam int AW      = WW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_re,
  input  logic             cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  input  logic             acc_valid,
  input  logic             acc_pref,
  input  logic             lock_mode,
  input  logic             rgn_direct,
  input  logic [NW-1:0]    hit,
  input  logic [NW-1:0]    valid,
  input  logic [NW*AW-1:0] age,
  output logic             fill_req,
  output logic [WW-1:0]    fill_way,
  output logic             wr_back,
  output logic             flush_pulse
);
  ctl_cfg_t  ctl;
  lock_cfg_t lck;

  cvs_cfg_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .re(cfg_re), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .ctl(ctl), .lck(lck),
    .flush_pulse(flush_pulse)
  );

  // lock bits only count in lock mode
  logic [NW-1:0] excl;
  always_comb begin
    excl         = '0;
    excl[WAY_LO] = lock_mode && lck.lock_lo;
    excl[WAY_HI] = lock_mode && lck.lock_hi;
  end

  logic [WW-1:0] victim;
  cvs_victim_pick #(.NW(NW), .AW(AW)) u_pick (
    .valid(valid), .age(age), .excl(excl), .victim(victim)
  );

  logic          miss;
  logic          steer;
  logic [WW-1:0] tgt;
  always_comb begin
    miss  = acc_valid && ctl.en && (hit == '0);
    steer = lock_mode && acc_pref;
    if (steer && lck.load_hi)      tgt = WW'(WAY_HI);
    else if (steer && lck.load_lo) tgt = WW'(WAY_LO);
    else                           tgt = victim;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_req <= 1'b0;
      fill_way <= '0;
      wr_back  <= 1'b0;
    end else begin
      fill_req <= miss;
      fill_way <= tgt;
      wr_back  <= rgn_direct ? ctl.pol_direct : !ctl.pol_other;
    end
  end

  // R8: a hit never produces a fill
  a_r8_no_fill_on_hit: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> ($past(hit) == '0));
  // R2: a disabled cache never fills
  a_r2_no_fill_when_off: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> $past(ctl.en));
  // R9: a locked upper way is never an ordinary-miss victim
  a_r9_hi_lock_kept: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !$past(acc_pref) && $past(lock_mode) && $past(lck.lock_hi))
      |-> (fill_way != WW'(WAY_HI)));
  a_r9_lo_lock_kept: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !$past(acc_pref) && $past(lock_mode) && $past(lck.lock_lo))
      |-> (fill_way != WW'(WAY_LO)));
endmodule

// File: tb/tb_cache_victim_ctl.sv
module tb_cache_victim_ctl;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_re, cfg_sel;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        acc_valid, acc_pref, lock_mode, rgn_direct;
  logic [3:0]  hit, valid;
  logic [7:0]  age;
  logic        fill_req, wr_back, flush_pulse;
  logic [1:0]  fill_way;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  cache_victim_ctl dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_pref(acc_pref), .lock_mode(lock_mode), .rgn_direct(rgn_direct),
    .hit(hit), .valid(valid), .age(age), .fill_req(fill_req),
    .fill_way(fill_way), .wr_back(wr_back), .flush_pulse(flush_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    cfg_re = 1'b1; cfg_sel = sel;
    @(negedge clk);
    cfg_re = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic lookup(input logic lk, input logic pf, input logic [3:0] h,
                        input logic [3:0] v, input logic [7:0] a);
    acc_valid = 1'b1; lock_mode = lk; acc_pref = pf; hit = h; valid = v; age = a;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // {lockreg[3:0], lk, pf, hit[3:0], valid[3:0], age[7:0], exp_req, exp_way[1:0]}
  // ages: E4 = way3 oldest .. way0 newest; 1B = way0 oldest; 6C = way1 oldest
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {4'hF, 1'b0, 1'b1, 4'h0, 4'hF, 8'hE4, 1'b1, 2'd3},  // R6 lock ignored
    {4'hF, 1'b1, 1'b1, 4'h0, 4'hF, 8'h1B, 1'b1, 2'd3},  // R7 load way3
    {4'h3, 1'b1, 1'b1, 4'h0, 4'hF, 8'h1B, 1'b1, 2'd2},  // R7 load way2
    {4'hA, 1'b1, 1'b1, 4'h0, 4'hF, 8'h1B, 1'b1, 2'd3},  // R7 way3 priority
    {4'h5, 1'b1, 1'b1, 4'h0, 4'hF, 8'hE4, 1'b1, 2'd1},  // R7 fallback
    {4'hF, 1'b1, 1'b0, 4'h0, 4'hF, 8'hE4, 1'b1, 2'd1},  // R9 both locked
    {4'h1, 1'b1, 1'b0, 4'h0, 4'hF, 8'hE4, 1'b1, 2'd3},  // R9 way2 locked
    {4'h4, 1'b1, 1'b0, 4'h0, 4'hF, 8'hE4, 1'b1, 2'd2},  // R9 way3 locked
    {4'h5, 1'b1, 1'b0, 4'h0, 4'hE, 8'hE4, 1'b1, 2'd0},  // R9 invalid first
    {4'h5, 1'b1, 1'b0, 4'h0, 4'h7, 8'h6C, 1'b1, 2'd1},  // R9 invalid but locked
    {4'hF, 1'b0, 1'b0, 4'h0, 4'hB, 8'h1B, 1'b1, 2'd2},  // R6 invalid way2 used
    {4'hF, 1'b1, 1'b1, 4'h1, 4'hF, 8'h1B, 1'b0, 2'd0},  // R8 pref hit way0
    {4'h0, 1'b0, 1'b0, 4'h4, 4'hF, 8'h1B, 1'b0, 2'd0},  // R8 plain hit
    {4'h0, 1'b0, 1'b0, 4'h0, 4'hF, 8'h6C, 1'b1, 2'd1}   // R9 oldest way1
  };

  initial begin
    logic [31:0] d;
    rst = 1'b1; cfg_we = 0; cfg_re = 0; cfg_sel = 0; cfg_wdata = '0;
    acc_valid = 0; acc_pref = 0; lock_mode = 0; rgn_direct = 0;
    hit = '0; valid = '0; age = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 fill_req", fill_req, 0);
    chk("R1 fill_way", fill_way, 0);
    chk("R1 wr_back", wr_back, 0);
    chk("R1 flush", flush_pulse, 0);
    rd(1'b0, d);
    chk("R1 ctl read", d, 0);

    // R2 disabled cache never fills
    lookup(1'b0, 1'b0, 4'h0, 4'hF, 8'hE4);
    chk("R2 off no fill", fill_req, 0);

    wr(1'b0, 32'h1);
    lookup(1'b0, 1'b0, 4'h0, 4'hF, 8'hE4);
    chk("R2 on fill", fill_req, 1);

    for (int i = 0; i < NV; i++) begin
      wr(1'b1, {28'd0, VEC[i][24:21]});
      lookup(VEC[i][20], VEC[i][19], VEC[i][18:15], VEC[i][14:11], VEC[i][10:3]);
      chk($sformatf("R7/R9 vec%0d req", i), fill_req, VEC[i][2]);
      if (VEC[i][2]) chk($sformatf("R7/R9 vec%0d way", i), fill_way, VEC[i][1:0]);
    end

    // R10 lock register reads zero
    wr(1'b1, 32'hF);
    rd(1'b1, d);
    chk("R10 lock read", d, 0);

    // R4 / R5 policy
    for (int p = 0; p < 4; p++) begin
      wr(1'b0, {28'd0, p[1], p[0], 1'b0, 1'b1});
      rgn_direct = 1'b1;
      @(negedge clk);
      chk("R4 direct policy", wr_back, p[0]);
      rgn_direct = 1'b0;
      @(negedge clk);
      chk("R5 other policy", wr_back, !p[1]);
    end

    // R3 flush strobe
    wr(1'b0, 32'h3);
    chk("R3 flush high", flush_pulse, 1);
    @(negedge clk);
    chk("R3 flush one cycle", flush_pulse, 0);
    rd(1'b0, d);
    chk("R3 flush reads 0", d, 32'h1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule